// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block watches each bus cycle and raises a bus error when no acceptable acknowledge arrives within a chosen number of clocks. An ordinary data cycle ends its wait only on the data-size acknowledge. An interrupt acknowledge cycle may end on either the data-size acknowledge or the autovector acknowledge. A 2-bit timing selector chooses a limit of 64, 32, 16 or 8 clocks.

Cycles that stay on the internal bus are always watched. A cycle that crosses from the internal to the external bus is watched only when the CPU started it and the external-monitor enable is set. If another master owns the external bus, that master's own monitor must cover it. The bus error stays asserted until the cycle-active input falls. The counter then clears and is ready for the next cycle.

Top module: `bus_resp_monitor`

## Requirements
- R1: `limit_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11 select limits of 64, 32, 16 and 8 clocks.
- R2: The count starts with the first rising clock edge at which `cyc_active` is high. `bus_err` goes high just after the edge on which a watched cycle reaches the limit without an acceptable acknowledge, and not one edge earlier.
- R3: When `cyc_iack`=0 (a normal cycle), only `ack_size` ends the wait. `ack_autovec` has no effect.
- R4: When `cyc_iack`=1 (an interrupt acknowledge cycle), either `ack_size` or `ack_autovec` ends the wait.
- R5: If an acceptable acknowledge is sampled on or before the limit-th edge, no bus error is raised. This includes an acknowledge on the limit-th edge itself. An acknowledge sampled one edge later is too late.
- R6: Once asserted, `bus_err` stays high for as long as `cyc_active` stays high.
- R7: After an edge that samples `cyc_active` low, `bus_err` is low and the count is back to zero for the next cycle.
- R8: An external cycle (`cyc_external`=1) with `cyc_by_cpu`=0 never raises `bus_err`.
- R9: An external cycle started by the CPU (`cyc_by_cpu`=1) is watched only when `ext_mon_en`=1.
- R10: An internal cycle (`cyc_external`=0) is watched whatever the value of `ext_mon_en`.
- R11: While `rst_n` is low, and just after it is released, `bus_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_active | input | 1 | High for the whole of a bus cycle |
| cyc_iack | input | 1 | 1 = interrupt acknowledge cycle, 0 = normal cycle |
| cyc_external | input | 1 | 1 = cycle goes from the internal to the external bus |
| cyc_by_cpu | input | 1 | 1 = the CPU started the cycle |
| ack_size | input | 1 | Data-size acknowledge |
| ack_autovec | input | 1 | Autovector acknowledge |
| limit_sel | input | 2 | Timeout selector (see R1) |
| ext_mon_en | input | 1 | Enables watching of CPU-started external cycles |
| bus_err | output | 1 | Bus error, held until the cycle ends |

## Verification
The embedded assertions check on every cycle these properties:
- an asserted error persists through an active cycle;
- an idle edge clears it;
- an unwatched or already-acknowledged cycle cannot raise it;
- the internal count never passes the decoded limit.

The exact error edge for each selector code is shown only by the bench's scenarios and its per-clock model. So are the same-edge acknowledge boundary, the rejection of the autovector acknowledge in normal cycles, and the initiator and enable qualification of external cycles.

// File: rtl/bm_pkg.sv
package bm_pkg;
  // Timeout selector width and the log2 of the shortest limit.
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned BASE_SHIFT = 3;
  localparam int unsigned NCODES     = 1 << SEL_W;
  // Counter wide enough to hold the longest limit.
  localparam int unsigned CNT_W      = BASE_SHIFT + NCODES;

  typedef struct packed {
    logic watched;
    logic ack_ok;
  } bm_qual_t;
endpackage

// File: rtl/bm_limit_decode.sv
module bm_limit_decode
  import bm_pkg::*;
(
  input  logic [SEL_W-1:0] limit_sel,
  output logic [CNT_W-1:0] limit
);
  logic [CNT_W-1:0] tbl [NCODES];

  // Code 0 selects the longest limit; each higher code halves it.
  for (genvar g = 0; g < NCODES; g++) begin : g_code
    assign tbl[g] = CNT_W'(1) << (BASE_SHIFT + NCODES - 1 - g);
  end

  assign limit = tbl[limit_sel];
endmodule

// File: rtl/bm_qualify.sv
module bm_qualify
  import bm_pkg::*;
(
  input  logic     cyc_iack,
  input  logic     cyc_external,
  input  logic     cyc_by_cpu,
  input  logic     ext_mon_en,
  input  logic     ack_size,
  input  logic     ack_autovec,
  output bm_qual_t qual
);
  always_comb begin
    // Internal cycles are always watched; external ones need CPU + enable.
    qual.watched = !cyc_external || (cyc_by_cpu && ext_mon_en);
    // Autovector is acceptable only in interrupt acknowledge cycles.
    qual.ack_ok  = ack_size || (cyc_iack && ack_autovec);
  end
endmodule

// File: rtl/bm_counter.sv
module bm_counter
  import bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_active,
  input  bm_qual_t         qual,
  input  logic [CNT_W-1:0] limit,
  output logic             bus_err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             upd_en;

  // The state changes only while a cycle runs, or to clear after one.
  assign upd_en = !cyc_active || (qual.watched && !done_q && !err_q);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    err_d  = err_q;
    if (!cyc_active) begin
      cnt_d  = '0;
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (qual.ack_ok) begin
      // An acknowledge on the limit edge still counts as in time.
      done_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_d == limit) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign bus_err = err_q;

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && cyc_active) |=> bus_err);
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_active |=> (!bus_err && cnt_q == '0));
  p_ack_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_err && cyc_active && qual.ack_ok) |=> !bus_err);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
  p_limit_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(limit) == 1);
endmodule

// File: rtl/bus_resp_monitor.sv
module bus_resp_monitor
  import bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_active,
  input  logic             cyc_iack,
  input  logic             cyc_external,
  input  logic             cyc_by_cpu,
  input  logic             ack_size,
  input  logic             ack_autovec,
  input  logic [SEL_W-1:0] limit_sel,
  input  logic             ext_mon_en,
  output logic             bus_err
);
  logic [CNT_W-1:0] limit;
  bm_qual_t         qual;

  bm_limit_decode u_dec (
    .limit_sel (limit_sel),
    .limit     (limit)
  );

  bm_qualify u_qual (
    .cyc_iack     (cyc_iack),
    .cyc_external (cyc_external),
    .cyc_by_cpu   (cyc_by_cpu),
    .ext_mon_en   (ext_mon_en),
    .ack_size     (ack_size),
    .ack_autovec  (ack_autovec),
    .qual         (qual)
  );

  bm_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_active (cyc_active),
    .qual       (qual),
    .limit      (limit),
    .bus_err    (bus_err)
  );

  // R8/R9/R10: an unwatched cycle cannot raise the error.
  p_unwatched_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_err && !(cyc_active && qual.watched)) |=> !bus_err);
endmodule

// File: tb/bus_resp_monitor_tb.sv
module bus_resp_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_active = 1'b0, cyc_iack = 1'b0, cyc_external = 1'b0, cyc_by_cpu = 1'b0;
  logic ack_size = 1'b0, ack_autovec = 1'b0, ext_mon_en = 1'b0;
  logic [1:0] limit_sel = 2'b00;
  logic bus_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_resp_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .cyc_iack(cyc_iack),
    .cyc_external(cyc_external), .cyc_by_cpu(cyc_by_cpu), .ack_size(ack_size),
    .ack_autovec(ack_autovec), .limit_sel(limit_sel), .ext_mon_en(ext_mon_en),
    .bus_err(bus_err)
  );

  // Behavioural reference model, updated on the same edges.
  int m_count;
  bit m_acked, m_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count = 0; m_acked = 0; m_err = 0;
    end else if (!cyc_active) begin
      m_count = 0; m_acked = 0; m_err = 0;
    end else if ((!cyc_external || (cyc_by_cpu && ext_mon_en)) && !m_acked && !m_err) begin
      if (ack_size || (cyc_iack && ack_autovec)) m_acked = 1;
      else begin
        m_count++;
        if (m_count == (64 >> limit_sel)) m_err = 1;
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus_err=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge.
  always @(negedge clk) if (rst_n && !done) check(bus_err, m_err, "R2 model");

  // Runs one cycle of 70 clocks. size_k / av_k: first edge with that ack (0 = never).
  task automatic run(input logic [1:0] sel, input bit iack, input bit ext,
                     input bit cpu, input bit en, input int size_k,
                     input int av_k, input string tag);
    int lim = 64 >> sel;
    bit watched = !ext || (cpu && en);
    int ok_k = 0;
    bit exp;
    if (size_k > 0) ok_k = size_k;
    if (iack && av_k > 0 && (ok_k == 0 || av_k < ok_k)) ok_k = av_k;
    exp = watched && !(ok_k > 0 && ok_k <= lim);
    @(negedge clk);
    limit_sel = sel; cyc_iack = iack; cyc_external = ext;
    cyc_by_cpu = cpu; ext_mon_en = en; cyc_active = 1'b1;
    for (int i = 1; i <= 70; i++) begin
      ack_size    = (size_k > 0 && i >= size_k);
      ack_autovec = (av_k > 0 && i >= av_k);
      @(negedge clk);
    end
    check(bus_err, exp, tag);          // also shows R6 hold: 70 > any limit
    cyc_active = 1'b0; ack_size = 1'b0; ack_autovec = 1'b0;
    @(negedge clk);
    check(bus_err, 1'b0, "R7 clear");
  endtask

  initial begin
    fork
      begin
        #5;
        check(bus_err, 1'b0, "R11 in reset");
        #50 rst_n = 1'b1;
        @(negedge clk);
        check(bus_err, 1'b0, "R11 after reset");
        run(2'b00, 0, 0, 0, 0, 0, 0, "R1 sel00 64");
        run(2'b01, 0, 0, 0, 0, 0, 0, "R1 sel01 32");
        run(2'b10, 0, 0, 0, 0, 0, 0, "R1 sel10 16");
        run(2'b11, 0, 0, 0, 0, 0, 0, "R1 sel11 8");
        run(2'b11, 0, 0, 0, 1, 0, 2, "R3 autovec ignored");
        run(2'b11, 0, 0, 0, 1, 8, 0, "R5 ack on limit edge");
        run(2'b11, 0, 0, 0, 1, 9, 0, "R5 ack one edge late");
        run(2'b10, 1, 0, 0, 0, 0, 16, "R4 autovec in iack");
        run(2'b10, 1, 0, 0, 0, 5, 0, "R4 size in iack");
        run(2'b11, 1, 0, 0, 0, 0, 9, "R4 late autovec");
        run(2'b11, 0, 1, 0, 1, 0, 0, "R8 other initiator");
        run(2'b11, 0, 1, 1, 0, 0, 0, "R9 enable off");
        run(2'b11, 0, 1, 1, 1, 0, 0, "R9 enable on");
        run(2'b10, 0, 0, 1, 0, 0, 0, "R10 internal en=0");
        run(2'b01, 0, 0, 0, 0, 33, 0, "R5 late at 32");
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog: actual timeout expected completion");
          done = 1'b1;
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule